// File: doc/BRIEF.md
# Signed Packed-Decimal Subtractor

This block computes A minus B for two signed packed-decimal numbers and reports how the true difference compares with zero. Each 128-bit operand carries 31 binary-coded decimal digits with the most significant digit at the top. The 4-bit sign code sits in the lowest nibble. The result uses the same layout. A four-bit condition field tells whether the difference was below, above or equal to zero. Its bottom bit flags either a magnitude that needed a 32nd digit or an operand that could not be decoded.

A caller places both operands and the preferred-sign bit on the inputs and raises `start` for one cycle while `busy` is low. The block first decides whether the magnitudes are added or subtracted and which one is larger. It then walks the digits serially, one per cycle, beginning with the least significant. On the final digit it loads the result and the flags and pulses `done`. Both outputs then hold until the next operation completes.

Top module: `pdec_subtractor`

## Requirements
- R1: The digit field is bits 127:4, with digit k (counting from the least significant, k = 0..30) at bits 4k+7:4k+4. Sign codes 0xA, 0xC, 0xE and 0xF denote positive operands, and 0xB and 0xD denote negative operands.
- R2: When either operand has a sign code from 0x0 to 0x9, or any digit nibble greater than 9, the flags are exactly 4'b0001. Flag bits are {LT, GT, EQ, SO} from bit 3 down to bit 0.
- R3: A negative difference yields sign code 0xD and LT set (4'b1000 when no overflow).
- R4: A positive non-zero difference yields GT set (4'b0100 when no overflow). Its sign code is 0xF when the preferred-sign input was 1 and 0xC when it was 0.
- R5: A zero true difference yields flags 4'b0010, all-zero digits and the preferred positive sign. A negative-zero operand counts as zero.
- R6: When the true magnitude needs more than 31 digits, SO is set along with LT or GT. The result then keeps the low 31 digits of the true magnitude and the correct sign.
- R7: Operand signs are honoured. When the sign of A and the negated sign of B agree, the magnitudes add. Otherwise the smaller magnitude is taken from the larger one, and the result takes the sign of the larger one.
- R8: After reset, `busy`, `done`, `result` and `flags` are all zero. `done` rises exactly 31 clock edges after the edge that accepts `start`, stays high for exactly one cycle, and `busy` is high in between.
- R9: A `start` pulse while `busy` is high is ignored. The operation in flight finishes with its own operands and its own preferred-sign value.
- R10: `result` and `flags` change only on the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only while idle |
| pref_sign | input | 1 | 1 selects 0xF, 0 selects 0xC, for non-negative results |
| opnd_a | input | 128 | Minuend, packed decimal |
| opnd_b | input | 128 | Subtrahend, packed decimal |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result and flags just updated |
| result | output | 128 | Packed-decimal difference |
| flags | output | 4 | {LT, GT, EQ, SO} |

## Verification
`result` and `flags` are due on the 31st rising edge after the edge that samples `start`, which is the same edge that raises `done`. The bench drives inputs on falling edges. After raising `start` it counts falling edges until it sees `done`. That count must equal 32, one for the accepting edge and 31 for the digit steps. Only then does the bench compare the outputs with its model. One falling edge later it checks that `done` has dropped and that `result` and `flags` have not moved. For invalid operands only the flags are compared.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam logic [3:0] SIGN_NEG      = 4'hD;
  localparam logic [3:0] SIGN_POS_PREF = 4'hF;
  localparam logic [3:0] SIGN_POS_STD  = 4'hC;

  localparam int unsigned FLG_LT = 3;
  localparam int unsigned FLG_GT = 2;
  localparam int unsigned FLG_EQ = 1;
  localparam int unsigned FLG_SO = 0;

  // Codes 0xA..0xF are legal signs; everything below is rejected.
  function automatic logic sign_ok(input logic [3:0] code);
    return code >= 4'hA;
  endfunction

  function automatic logic sign_neg(input logic [3:0] code);
    return (code == 4'hB) || (code == 4'hD);
  endfunction

  // One decimal digit step: returns {carry_or_borrow, digit}.
  function automatic logic [4:0] digit_step(input logic [3:0] x,
                                            input logic [3:0] y,
                                            input logic       cin,
                                            input logic       sub);
    logic [4:0] t;
    if (sub) begin
      t = {1'b0, x} + 5'd10 - {1'b0, y} - {4'b0000, cin};
      if (t >= 5'd10) begin
        t = t - 5'd10;
        return {1'b0, t[3:0]};
      end
      return {1'b1, t[3:0]};
    end
    t = {1'b0, x} + {1'b0, y} + {4'b0000, cin};
    if (t > 5'd9) begin
      t = t - 5'd10;
      return {1'b1, t[3:0]};
    end
    return {1'b0, t[3:0]};
  endfunction

  function automatic logic [3:0] pick_sign(input logic neg, input logic pref);
    if (neg) return SIGN_NEG;
    return pref ? SIGN_POS_PREF : SIGN_POS_STD;
  endfunction

  function automatic logic [3:0] make_flags(input logic bad,
                                            input logic nonzero,
                                            input logic ovf,
                                            input logic neg);
    logic [3:0] f;
    f = 4'b0000;
    if (bad) begin
      f[FLG_SO] = 1'b1;
    end else if (!nonzero && !ovf) begin
      f[FLG_EQ] = 1'b1;
    end else begin
      f[FLG_LT] = neg;
      f[FLG_GT] = !neg;
      f[FLG_SO] = ovf;
    end
    return f;
  endfunction

endpackage

// File: rtl/pdec_operand_check.sv
module pdec_operand_check
  import pdec_pkg::*;
#(
  parameter int unsigned DIGITS = 31
)
(
  input  logic [DIGITS*4+3:0] opnd,
  output logic                valid,
  output logic                neg,
  output logic                zero
);
  logic [DIGITS-1:0] dig_bad;
  logic [DIGITS-1:0] dig_nz;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    localparam int unsigned LSB = 4 + 4 * g;
    assign dig_bad[g] = opnd[LSB+3:LSB] > 4'd9;
    assign dig_nz[g]  = opnd[LSB+3:LSB] != 4'd0;
  end

  assign valid = sign_ok(opnd[3:0]) && !(|dig_bad);
  assign neg   = sign_neg(opnd[3:0]);
  assign zero  = !(|dig_nz);
endmodule

// File: rtl/pdec_mag_compare.sv
module pdec_mag_compare #(
  parameter int unsigned DIGITS = 31
)
(
  input  logic [DIGITS*4-1:0] mag_x,
  input  logic [DIGITS*4-1:0] mag_y,
  output logic                x_gt_y,
  output logic                x_eq_y
);
  // Scan digits from the top: the first unequal digit decides.
  logic [DIGITS:0] gt_chain;
  logic [DIGITS:0] eq_chain;

  assign gt_chain[DIGITS] = 1'b0;
  assign eq_chain[DIGITS] = 1'b1;

  for (genvar g = DIGITS - 1; g >= 0; g--) begin : g_cmp
    logic [3:0] dx;
    logic [3:0] dy;
    assign dx = mag_x[4*g+3:4*g];
    assign dy = mag_y[4*g+3:4*g];
    assign gt_chain[g] = gt_chain[g+1] || (eq_chain[g+1] && (dx > dy));
    assign eq_chain[g] = eq_chain[g+1] && (dx == dy);
  end

  assign x_gt_y = gt_chain[0];
  assign x_eq_y = eq_chain[0];
endmodule

// File: rtl/pdec_digit_unit.sv
module pdec_digit_unit
  import pdec_pkg::*;
(
  input  logic [3:0] dig_x,
  input  logic [3:0] dig_y,
  input  logic       cin,
  input  logic       sub,
  output logic [3:0] dig_out,
  output logic       cout
);
  logic [4:0] step;
  assign step    = digit_step(dig_x, dig_y, cin, sub);
  assign dig_out = step[3:0];
  assign cout    = step[4];
endmodule

// File: rtl/pdec_subtractor.sv
module pdec_subtractor
  import pdec_pkg::*;
#(
  parameter int unsigned DIGITS = 31
)
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                pref_sign,
  input  logic [DIGITS*4+3:0] opnd_a,
  input  logic [DIGITS*4+3:0] opnd_b,
  output logic                busy,
  output logic                done,
  output logic [DIGITS*4+3:0] result,
  output logic [3:0]          flags
);
  localparam int unsigned MW = DIGITS * 4;
  localparam int unsigned W  = MW + 4;
  localparam int unsigned IW = $clog2(DIGITS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DIGITS - 1);

  // operand classification
  logic a_valid, a_neg, a_zero;
  logic b_valid, b_neg, b_zero;
  logic a_gt_b, mag_eq;

  pdec_operand_check #(.DIGITS(DIGITS)) u_check_a (
    .opnd (opnd_a), .valid(a_valid), .neg(a_neg), .zero(a_zero)
  );
  pdec_operand_check #(.DIGITS(DIGITS)) u_check_b (
    .opnd (opnd_b), .valid(b_valid), .neg(b_neg), .zero(b_zero)
  );
  pdec_mag_compare #(.DIGITS(DIGITS)) u_cmp (
    .mag_x (opnd_a[W-1:4]), .mag_y(opnd_b[W-1:4]),
    .x_gt_y(a_gt_b),        .x_eq_y(mag_eq)
  );

  // Effective signs of A and of -B; a zero magnitude is always positive.
  logic a_eff_neg, b_eff_neg, mode_sub, swap, res_neg_d, bad_d;
  assign a_eff_neg = a_neg && !a_zero;
  assign b_eff_neg = !b_neg && !b_zero;
  assign mode_sub  = a_eff_neg ^ b_eff_neg;
  assign swap      = mode_sub && !a_gt_b;
  assign res_neg_d = mode_sub ? (!mag_eq && (a_gt_b ? a_eff_neg : b_eff_neg))
                              : a_eff_neg;
  assign bad_d     = !(a_valid && b_valid);

  // sequencing state
  run_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [MW-1:0] big_q, small_q, acc_q;
  logic          carry_q, sub_q, neg_q, ps_q, bad_q, nz_q;

  // named events for the checker
  logic accept;
  logic last_digit;
  assign busy       = (state_q == ST_RUN);
  assign accept     = start && !busy;
  assign last_digit = busy && (idx_q == LAST_IDX);

  logic [3:0] dig_res;
  logic       dig_cout;
  pdec_digit_unit u_digit (
    .dig_x  (big_q[3:0]),
    .dig_y  (small_q[3:0]),
    .cin    (carry_q),
    .sub    (sub_q),
    .dig_out(dig_res),
    .cout   (dig_cout)
  );

  logic       nz_final, ovf_final;
  assign nz_final  = nz_q || (dig_res != 4'd0);
  assign ovf_final = dig_cout && !sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      big_q   <= '0;
      small_q <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
      sub_q   <= 1'b0;
      neg_q   <= 1'b0;
      ps_q    <= 1'b0;
      bad_q   <= 1'b0;
      nz_q    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      flags   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        idx_q   <= '0;
        big_q   <= swap ? opnd_b[W-1:4] : opnd_a[W-1:4];
        small_q <= swap ? opnd_a[W-1:4] : opnd_b[W-1:4];
        acc_q   <= '0;
        carry_q <= 1'b0;
        sub_q   <= mode_sub;
        neg_q   <= res_neg_d;
        ps_q    <= pref_sign;
        bad_q   <= bad_d;
        nz_q    <= 1'b0;
      end else if (busy) begin
        big_q   <= {4'h0, big_q[MW-1:4]};
        small_q <= {4'h0, small_q[MW-1:4]};
        acc_q   <= {dig_res, acc_q[MW-1:4]};
        carry_q <= dig_cout;
        nz_q    <= nz_final;
        idx_q   <= idx_q + 1'b1;
        if (last_digit) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
          result  <= {dig_res, acc_q[MW-1:4], pick_sign(neg_q, ps_q)};
          flags   <= make_flags(bad_q, nz_final, ovf_final, neg_q);
        end
      end
    end
  end
endmodule

// File: rtl/pdec_subtractor_chk.sv
module pdec_subtractor_chk #(
  parameter int unsigned DIGITS = 31
)
(
  input logic                clk,
  input logic                rst_n,
  input logic                accept,
  input logic                busy,
  input logic                done,
  input logic                ps_held,
  input logic [DIGITS*4+3:0] result,
  input logic [3:0]          flags
);
  int unsigned lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_cnt <= 0;
    else if (accept) lat_cnt <= 0;
    else if (busy)   lat_cnt <= lat_cnt + 1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == DIGITS)); // R8
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ps_held)); // R9
  AST_FLAG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (($countones(flags[3:1]) == 1) || (flags == 4'b0001))); // R2
  AST_NEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags[3]) |-> (result[3:0] == 4'hD)); // R3
  AST_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (flags[2] || flags[1])) |-> (result[3:0] == (ps_held ? 4'hF : 4'hC))); // R4
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags[1]) |-> ((result[DIGITS*4+3:4] == '0) && !flags[0])); // R5
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(flags))); // R10
endmodule

bind pdec_subtractor pdec_subtractor_chk #(.DIGITS(DIGITS)) u_pdec_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .accept (accept),
  .busy   (busy),
  .done   (done),
  .ps_held(ps_q),
  .result (result),
  .flags  (flags)
);

// File: tb/test_pdec_subtractor.sv
module test_pdec_subtractor;
  localparam int unsigned DIGITS     = 31;
  localparam int unsigned W          = DIGITS * 4 + 4;
  localparam int unsigned TD         = DIGITS + 2;
  localparam int unsigned TW         = TD * 4;
  localparam int unsigned CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          pref_sign = 1'b0;
  logic [W-1:0]  opnd_a = '0;
  logic [W-1:0]  opnd_b = '0;
  logic          busy, done;
  logic [W-1:0]  result;
  logic [3:0]    flags;

  int total = 0;
  int bad = 0;

  pdec_subtractor #(.DIGITS(DIGITS)) i_pdec_subtractor (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_sign(pref_sign),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .result(result), .flags(flags)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ten's complement arithmetic over TD digits
  function automatic logic [TW-1:0] tc_add(input logic [TW-1:0] x, input logic [TW-1:0] y);
    logic [TW-1:0] s;
    int c;
    s = '0;
    c = 0;
    for (int i = 0; i < TD; i++) begin
      int t;
      t = int'(x[4*i +: 4]) + int'(y[4*i +: 4]) + c;
      c = t / 10;
      s[4*i +: 4] = 4'(t % 10);
    end
    return s;
  endfunction

  function automatic logic [TW-1:0] tc_neg(input logic [TW-1:0] x);
    logic [TW-1:0] n;
    for (int i = 0; i < TD; i++) n[4*i +: 4] = 4'(9 - int'(x[4*i +: 4]));
    return tc_add(n, TW'(1));
  endfunction

  function automatic bit tb_legal(input logic [W-1:0] v);
    if (v[3:0] < 4'hA) return 1'b0;
    for (int i = 1; i <= DIGITS; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit tb_minus(input logic [3:0] code);
    return code == 4'hB || code == 4'hD;
  endfunction

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                       output logic [W-1:0] res, output logic [3:0] fl);
    logic [TW-1:0] va, vb, s, mag;
    bit neg;
    res = '0;
    if (!tb_legal(a) || !tb_legal(b)) begin
      fl = 4'b0001;
      return;
    end
    va = {8'h00, a[W-1:4]};
    vb = {8'h00, b[W-1:4]};
    if (tb_minus(a[3:0])) va = tc_neg(va);
    if (!tb_minus(b[3:0])) vb = tc_neg(vb);
    s   = tc_add(va, vb);
    neg = s[TW-1 -: 4] >= 4'd5;
    mag = neg ? tc_neg(s) : s;
    if (mag == '0) fl = 4'b0010;
    else fl = {neg, !neg, 1'b0, mag[TW-1 : W-4] != '0};
    res = {mag[W-5:0], neg ? 4'hD : (p ? 4'hF : 4'hC)};
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                        input string req, input bit poke);
    logic [W-1:0] er;
    logic [3:0]   ef;
    logic [W-1:0] r_seen;
    logic [3:0]   f_seen;
    int n;
    model(a, b, p, er, ef);
    @(negedge clk);
    opnd_a = a; opnd_b = b; pref_sign = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      check("R9", "busy during run", W'(busy), W'(1));
      opnd_a = b; opnd_b = a; pref_sign = !p; start = 1'b1;
      @(negedge clk);
      n++;
      start = 1'b0;
    end
    while (!done && n < DIGITS + 10) begin
      @(negedge clk);
      n++;
    end
    check("R8", "done latency", W'(n), W'(DIGITS + 1));
    check(req, "flags", W'(flags), W'(ef));
    if (ef != 4'b0001) check(req, "result", result, er);
    r_seen = result;
    f_seen = flags;
    @(negedge clk);
    check("R8", "done one cycle", W'(done), W'(0));
    check("R10", "result held", result, r_seen);
    check("R10", "flags held", W'(flags), W'(f_seen));
  endtask

  function automatic logic [W-1:0] rnd_opnd(input bit make_bad);
    logic [W-1:0] v;
    int unsigned len;
    int unsigned pos;
    v = '0;
    len = $urandom_range(DIGITS, 0);
    if ($urandom_range(3, 0) == 0) len = DIGITS;
    for (int i = 0; i < DIGITS; i++)
      if (i < int'(len)) v[4 + 4*i +: 4] = 4'($urandom_range(9, 0));
    v[3:0] = 4'($urandom_range(15, 10));
    if (make_bad) begin
      if ($urandom_range(1, 0) == 1) v[3:0] = 4'($urandom_range(9, 0));
      else begin
        pos = $urandom_range(DIGITS - 1, 0);
        v[4 + 4*pos +: 4] = 4'($urandom_range(15, 10));
      end
    end
    return v;
  endfunction

  function automatic logic [W-1:0] mk(input logic [W-5:0] digs, input logic [3:0] sgn);
    return {digs, sgn};
  endfunction

  logic [W-5:0] all9;
  logic [W-5:0] one;
  assign all9 = {DIGITS{4'h9}};
  assign one  = (W-4)'(1);

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "reset busy", W'(busy), W'(0));
    check("R8", "reset done", W'(done), W'(0));
    check("R8", "reset flags", W'(flags), W'(0));
    check("R8", "reset result", result, '0);
    rst_n = 1'b1;

    run_op(mk(all9, 4'hC), mk(all9, 4'hC), 1'b0, "R5", 0);
    run_op(mk(all9, 4'hC), mk(all9, 4'hC), 1'b1, "R5", 0);
    run_op(mk('0, 4'hD), mk('0, 4'hC), 1'b0, "R5", 0);   // -0 - +0
    run_op(mk('0, 4'hC), mk('0, 4'hB), 1'b1, "R5", 0);   // +0 - -0
    run_op(mk(all9, 4'hC), mk(one, 4'hD), 1'b0, "R6", 0);
    run_op(mk(all9, 4'hD), mk(one, 4'hC), 1'b1, "R6", 0);
    run_op(mk(all9 - 1, 4'hC), mk(one, 4'hD), 1'b1, "R4", 0);
    run_op(mk(all9 - 1, 4'hC), mk(one, 4'hD), 1'b0, "R4", 0);
    run_op(mk('0, 4'hC), mk(one, 4'hC), 1'b1, "R3", 0);
    run_op(mk((W-4)'(5), 4'hD), mk((W-4)'(7), 4'hD), 1'b0, "R7", 0);
    run_op(mk((W-4)'(5), 4'hC), mk((W-4)'(7), 4'hD), 1'b0, "R7", 0);
    run_op(mk((W-4)'(48), 4'hA), mk((W-4)'(19), 4'hE), 1'b1, "R1", 0);
    run_op(mk((W-4)'(3), 4'hB), mk((W-4)'(3), 4'hF), 1'b0, "R1", 0);
    run_op(mk(one, 4'hC), mk((W-4)'(15), 4'h0), 1'b0, "R2", 0);
    run_op(mk((W-4)'(15), 4'h0), mk(one, 4'hC), 1'b1, "R2", 0);
    run_op(mk((W-4)'(10), 4'hC), mk(one, 4'hC), 1'b0, "R2", 0); // digit 0xA
    run_op(mk((W-4)'(2), 4'hC), mk((W-4)'(9), 4'hC), 1'b1, "R9", 1);

    for (int k = 0; k < 60; k++) begin
      bit inj;
      inj = ($urandom_range(9, 0) == 0);
      run_op(rnd_opnd(inj), rnd_opnd(1'b0), 1'($urandom_range(1, 0)), "R7",
             $urandom_range(7, 0) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule